// File: doc/BRIEF.md
# Reset Generator with Cause Tracking

This block produces the system reset for a small chip and keeps a few sticky register bits that boot software reads to learn which kind of reset happened last. Reset can come from four places: a cold power-on input, an active-low board pin, a one-cycle watchdog expiry pulse, and software writes to the configuration register. A software write can ask for a full reset, which reloads a strap-driven enable bit, or for a soft reset, which leaves a request bit standing. Each kind of reset clears or keeps a different set of bits, so the surviving bits identify the cause.

Boot software classifies the cause by testing in a fixed order. If the boot flag is 0, the reset was cold. Otherwise, if the strap-loaded enable is 1, it was a full software reset. Otherwise, if the soft request is 1, it was a soft reset. Otherwise it was the pin or the watchdog, and the watchdog status bit separates those two. After classifying, software writes the boot flag to 1 and the enable and soft request to 0, which prepares the bits for the next reset. The system reset output stays asserted while any source is active and for a fixed stretch of cycles after the last one.

Top module: `rstctl_top`

## Requirements
- R1: While `por_n` is low, and after it rises, the configuration register (address 0) holds boot flag bit0=0, enable bit1=`strap_en`, soft request bit2=0. The status register (address 1) holds watchdog bit0=0.
- R2: Boot flag bit0 changes only on a software write to address 0 or on a cold reset. Full, soft, pin and watchdog resets all keep it.
- R3: A write to address 0 with bit3=1 starts a full reset. The same write loads the enable bit from `strap_en` and clears the soft request. Bit3 always reads 0.
- R4: A write to address 0 with bit2=1 starts a soft reset. The soft request bit stays 1 through that reset until software writes it to 0.
- R5: When `ext_rst_n` is low, it passes through a two-flop synchronizer and then asserts reset. The pin reset clears the soft request and keeps the boot flag, the enable bit and the watchdog bit.
- R6: A `wdog_bite` pulse asserts reset and acts on the configuration bits exactly as the pin does. It also sets status bit0.
- R7: Status bit0 clears when software writes 1 to it and does not change when software writes 0.
- R8: `sys_rst_n` stays low for exactly 16 cycles after the last cycle in which any source was active. A new event during the stretch restarts the count.
- R9: `rdata` shows the register selected by `addr` one clock after the address is presented. Addresses 2 and 3 read 0.
- R10: When a hardware reset effect and a software write hit the same bit in the same cycle, the hardware effect wins. A watchdog set beats a clear, and a pin or watchdog clear beats a soft request write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous to clk |
| wdog_bite | input | 1 | One-cycle watchdog expiry pulse |
| strap_en | input | 1 | Strap level loaded into the enable bit |
| we | input | 1 | Register write enable |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data |
| sys_rst_n | output | 1 | System reset output, active low |

## Verification
Two collisions are provoked by lining up stimulus on the same negative edge. In the first, a watchdog pulse arrives in the cycle that software writes 1 to clear the watchdog status bit. In the second, a watchdog pulse arrives together with a write that sets the soft request. In both cases the scoreboard expects the hardware effect to win: the status bit reads 1 and the soft request reads 0. A third overlap, a second watchdog pulse arriving inside an unfinished reset stretch, is judged by sampling `sys_rst_n` on the 15th and 16th cycles after the second pulse.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
   localparam int CFG_FLAG  = 0;
   localparam int CFG_EN    = 1;
   localparam int CFG_SOFT  = 2;
   localparam int CFG_FULL  = 3;
   localparam int STAT_WDOG = 0;

   typedef struct packed {
      logic soft_req;
      logic en;
      logic flag;
   } cfg_t;
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic d_async,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n)
               if (!por_n) chain[0] <= 1'b1;
               else        chain[0] <= d_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n)
               if (!por_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic active,
   output logic rst_n
);
   localparam int CW = $clog2(HOLD_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n)
      if (!por_n)          cnt <= LOAD;
      else if (active)     cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;

   assign rst_n = (cnt == '0);
endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
   import rstctl_pkg::*;
#(
   parameter int AW = 2,
   parameter int DW = 8,
   parameter logic [AW-1:0] ADDR_CFG  = '0,
   parameter logic [AW-1:0] ADDR_STAT = 1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          strap,
   input  logic          hw_clr,
   input  logic          wdog_set,
   output logic [DW-1:0] rdata,
   output cfg_t          cfg,
   output logic          wdog_hit,
   output logic          full_go,
   output logic          soft_go
);
   logic wr_cfg, wr_stat;

   assign wr_cfg  = we && (addr == ADDR_CFG);
   assign wr_stat = we && (addr == ADDR_STAT);
   assign full_go = wr_cfg && wdata[CFG_FULL];
   assign soft_go = wr_cfg && wdata[CFG_SOFT];

   always_ff @(posedge clk or negedge por_n)
      if (!por_n) begin
         cfg.flag     <= 1'b0;
         cfg.en       <= strap;
         cfg.soft_req <= 1'b0;
         wdog_hit     <= 1'b0;
      end else begin
         if (wr_cfg) begin
            cfg.flag     <= wdata[CFG_FLAG];
            cfg.en       <= wdata[CFG_EN];
            cfg.soft_req <= wdata[CFG_SOFT];
         end
         if (hw_clr) cfg.soft_req <= 1'b0;
         if (full_go) begin
            cfg.en       <= strap;
            cfg.soft_req <= 1'b0;
         end
         if (wr_stat && wdata[STAT_WDOG]) wdog_hit <= 1'b0;
         if (wdog_set)                    wdog_hit <= 1'b1;
      end

   logic [DW-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (addr == ADDR_CFG) begin
         rd_mux[CFG_FLAG] = cfg.flag;
         rd_mux[CFG_EN]   = cfg.en;
         rd_mux[CFG_SOFT] = cfg.soft_req;
      end else if (addr == ADDR_STAT) begin
         rd_mux[STAT_WDOG] = wdog_hit;
      end
   end

   always_ff @(posedge clk or negedge por_n)
      if (!por_n) rdata <= '0;
      else        rdata <= rd_mux;
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
   import rstctl_pkg::*;
#(
   parameter int AW          = 2,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 16,
   parameter logic [AW-1:0] ADDR_CFG  = '0,
   parameter logic [AW-1:0] ADDR_STAT = 1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          ext_rst_n,
   input  logic          wdog_bite,
   input  logic          strap_en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          sys_rst_n
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (DW < 4) begin : g_bad_dw
         $error("DW must hold the four config bits");
      end
      if (ADDR_CFG == ADDR_STAT) begin : g_bad_map
         $error("register addresses must differ");
      end
   endgenerate

   logic pin_sync, pin_act;
   logic full_go, soft_go, any_src;
   cfg_t cfg;
   logic wdog_hit;

   rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .d_async(ext_rst_n), .q(pin_sync)
   );
   assign pin_act = ~pin_sync;

   rstctl_regs #(.AW(AW), .DW(DW), .ADDR_CFG(ADDR_CFG), .ADDR_STAT(ADDR_STAT)) u_regs (
      .clk(clk), .por_n(por_n), .we(we), .addr(addr), .wdata(wdata),
      .strap(strap_en), .hw_clr(pin_act | wdog_bite), .wdog_set(wdog_bite),
      .rdata(rdata), .cfg(cfg), .wdog_hit(wdog_hit),
      .full_go(full_go), .soft_go(soft_go)
   );

   assign any_src = pin_act | wdog_bite | full_go | soft_go;

   rstctl_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
      .clk(clk), .por_n(por_n), .active(any_src), .rst_n(sys_rst_n)
   );
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
   parameter int AW = 2,
   parameter logic [AW-1:0] ADDR_CFG = '0
) (
   input logic          clk,
   input logic          por_n,
   input logic          we,
   input logic [AW-1:0] addr,
   input logic [7:0]    wdata,
   input logic          wdog_bite,
   input logic          strap_en,
   input logic          sys_rst_n,
   input logic          flag,
   input logic          en,
   input logic          soft_req,
   input logic          wdog_hit,
   input logic          pin_act
);
   logic wr_cfg;
   assign wr_cfg = we && (addr == ADDR_CFG);

   a_r2_flag_hold: assert property (@(posedge clk) disable iff (!por_n)
      !wr_cfg |=> $stable(flag));

   a_r3_full_strap: assert property (@(posedge clk) disable iff (!por_n)
      (wr_cfg && wdata[3]) |=> (en == $past(strap_en)) && !soft_req && !sys_rst_n);

   a_r4_soft_hold: assert property (@(posedge clk) disable iff (!por_n)
      (soft_req && !wr_cfg && !pin_act && !wdog_bite) |=> soft_req);

   a_r5_pin_keeps_en: assert property (@(posedge clk) disable iff (!por_n)
      (pin_act && !wr_cfg) |=> $stable(en) && !soft_req);

   a_r6_wdog_sets: assert property (@(posedge clk) disable iff (!por_n)
      wdog_bite |=> wdog_hit && !sys_rst_n);

   a_r8_quiet_release: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst_n) |-> $past(!wdog_bite && !pin_act));
endmodule

bind rstctl_top rstctl_chk #(.AW(AW), .ADDR_CFG(ADDR_CFG)) u_chk (
   .clk(clk), .por_n(por_n), .we(we), .addr(addr), .wdata(wdata[7:0]),
   .wdog_bite(wdog_bite), .strap_en(strap_en), .sys_rst_n(sys_rst_n),
   .flag(cfg.flag), .en(cfg.en), .soft_req(cfg.soft_req),
   .wdog_hit(wdog_hit), .pin_act(pin_act)
);

// File: tb/sim_rstctl_top.sv
`timescale 1ns/1ps
module sim_rstctl_top;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic por_n = 1'b0, ext_rst_n = 1'b1, wdog_bite = 1'b0, strap_en = 1'b1;
   logic we = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic sys_rst_n;

   int total = 0, bad = 0;

   rstctl_top u0 (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdog_bite(wdog_bite),
      .strap_en(strap_en), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .sys_rst_n(sys_rst_n)
   );

   logic [7:0] exp_q[$];
   string      tag_q[$];
   event       smp;

   // monitor: pops expectations as read results appear
   initial forever begin
      @(smp);
      if (exp_q.size() != 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         total++;
         if (rdata !== e) begin
            bad++;
            $display("FAIL %s rdata=%h expected=%h", t, rdata, e);
         end
      end
   end

   task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      addr = a;
      @(posedge clk);
      @(negedge clk);
      ->smp;
      #0.1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic chk_rst(input logic e, input string t);
      total++;
      if (sys_rst_n !== e) begin
         bad++;
         $display("FAIL %s sys_rst_n=%b expected=%b", t, sys_rst_n, e);
      end
   endtask

   task automatic chk_str(input string got, input string e, input string t);
      total++;
      if (got != e) begin
         bad++;
         $display("FAIL %s cause=%s expected=%s", t, got, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // software cause decode in priority order
   function automatic string classify(input logic [7:0] c, input logic [7:0] s);
      if (!c[0])      return "cold";
      else if (c[1])  return "full";
      else if (c[2])  return "soft";
      else if (s[0])  return "wdog";
      else            return "pin";
   endfunction

   logic [7:0] cfg_v, st_v;
   task automatic snap();
      @(negedge clk); addr = 2'd0; @(posedge clk); @(negedge clk); cfg_v = rdata;
      addr = 2'd1; @(posedge clk); @(negedge clk); st_v = rdata;
   endtask

   bit done = 0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 cold reset state
      repeat (3) @(negedge clk);
      chk_rst(1'b0, "R1 reset during por");
      por_n = 1'b1;
      repeat (15) @(posedge clk);
      @(negedge clk); chk_rst(1'b0, "R8 por stretch cycle 15");
      @(posedge clk); @(negedge clk); chk_rst(1'b1, "R8 por stretch cycle 16");
      rd_expect(2'd0, 8'h02, "R1 cfg after cold");
      rd_expect(2'd1, 8'h00, "R1 stat after cold");
      snap(); chk_str(classify(cfg_v, st_v), "cold", "R1 decode cold");
      wr(2'd0, 8'h01);
      rd_expect(2'd0, 8'h01, "R2 boot write");

      // R4 soft reset
      wr(2'd0, 8'h05);
      chk_rst(1'b0, "R4 soft asserts");
      idle(20);
      rd_expect(2'd0, 8'h05, "R4 soft persists, R2 flag kept");
      snap(); chk_str(classify(cfg_v, st_v), "soft", "R4 decode soft");
      wr(2'd0, 8'h01);
      rd_expect(2'd0, 8'h01, "R4 soft cleared by write");

      // R3 full reset with soft also requested
      wr(2'd0, 8'h0D);
      chk_rst(1'b0, "R3 full asserts");
      repeat (15) @(posedge clk);
      @(negedge clk); chk_rst(1'b0, "R8 full stretch cycle 15");
      @(posedge clk); @(negedge clk); chk_rst(1'b1, "R8 full stretch cycle 16");
      rd_expect(2'd0, 8'h03, "R3 strap reload, soft clear, bit3 reads 0");
      snap(); chk_str(classify(cfg_v, st_v), "full", "R3 decode full");
      wr(2'd0, 8'h01);

      // R5 pin reset
      wr(2'd0, 8'h05);
      idle(20);
      ext_rst_n = 1'b0;
      idle(3);
      chk_rst(1'b0, "R5 pin asserts after sync");
      idle(2);
      ext_rst_n = 1'b1;
      idle(22);
      chk_rst(1'b1, "R5 pin released");
      rd_expect(2'd0, 8'h01, "R5 pin clears soft keeps flag and en");
      rd_expect(2'd1, 8'h00, "R5 pin leaves wdog bit");
      snap(); chk_str(classify(cfg_v, st_v), "pin", "R5 decode pin");

      // R6 watchdog reset, strap high must not reload
      @(negedge clk); wdog_bite = 1'b1;
      @(negedge clk); wdog_bite = 1'b0;
      chk_rst(1'b0, "R6 wdog asserts");
      idle(20);
      rd_expect(2'd0, 8'h01, "R6 wdog cfg like pin");
      rd_expect(2'd1, 8'h01, "R6 wdog status set");
      snap(); chk_str(classify(cfg_v, st_v), "wdog", "R6 decode wdog");

      // R7 clear semantics
      wr(2'd1, 8'h00);
      rd_expect(2'd1, 8'h01, "R7 write 0 no effect");
      wr(2'd1, 8'h01);
      rd_expect(2'd1, 8'h00, "R7 write 1 clears");

      // R10 collisions
      @(negedge clk); we = 1'b1; addr = 2'd1; wdata = 8'h01; wdog_bite = 1'b1;
      @(negedge clk); we = 1'b0; wdog_bite = 1'b0;
      rd_expect(2'd1, 8'h01, "R10 wdog set beats clear");
      @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 8'h05; wdog_bite = 1'b1;
      @(negedge clk); we = 1'b0; wdog_bite = 1'b0;
      rd_expect(2'd0, 8'h01, "R10 wdog clear beats soft write");
      wr(2'd1, 8'h01);

      // R8 overlap restarts stretch
      idle(20);
      @(negedge clk); wdog_bite = 1'b1;
      @(negedge clk); wdog_bite = 1'b0;
      idle(9);
      wdog_bite = 1'b1;
      @(negedge clk); wdog_bite = 1'b0;
      repeat (15) @(posedge clk);
      @(negedge clk); chk_rst(1'b0, "R8 overlap cycle 15");
      @(posedge clk); @(negedge clk); chk_rst(1'b1, "R8 overlap cycle 16");

      // R9 unmapped
      rd_expect(2'd2, 8'h00, "R9 addr 2 reads 0");
      rd_expect(2'd3, 8'h00, "R9 addr 3 reads 0");

      // R1 second cold reset with strap low
      strap_en = 1'b0;
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      rd_expect(2'd0, 8'h00, "R1 cold clears flag, en from strap");
      rd_expect(2'd1, 8'h00, "R1 cold clears wdog bit");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule